// File: doc/BRIEF.md
# Multichannel Programmable Audio Delay Line

This block holds PCM samples in one shared on-chip sample memory and plays them back later. Each of eight output channels has its own delay, counted in whole sample periods. The receiver side offers samples one at a time, each with a 3-bit channel index and a strobe. The transmitter side asks for a channel's sample, and the block answers one cycle later. Channel index `c` means stereo lane `c[2:1]`, with `c[0]` = 0 for left and 1 for right.

In eight-channel mode, input channel `c` is delayed by delay register `c` and comes back on output channel `c`. The memory is split into eight equal regions, one per channel. In two-channel mode, only one stereo input lane is stored, picked by a 2-bit select. Output channel `c` reads the left or right sample of that lane (given by `c[0]`) through delay register `c`, so four output lanes carry independently delayed copies of one stereo pair. Here the memory is split into two regions: left and right. A frame ends on the input side with the last stored channel, and on the output side with the request for channel 7. The difference between the two frame counts is the fill level. The block stops with a flag when this level falls to zero at the start of an output frame, or would exceed a fixed slack.

Top module: `av_delay_line`

## Requirements
- R1: After reset, `running`, `cfg_error`, `overrun`, `underrun` and `out_valid` are 0, and `out_data` is 0.
- R2: A rising edge of `cfg_enable` starts a run. The run starts only if every delay is at most the limit for the requested mode: DEPTH/8-1-SLACK in eight-channel mode (`cfg_eight_ch`=1), or DEPTH/2-1-SLACK in two-channel mode (`cfg_eight_ch`=0). If the delays are valid, `running` is 1 from the next cycle and `cfg_error` is 0. Otherwise `cfg_error` is 1 and `running` stays 0.
- R3: While `running` is 0, every request returns `out_data` = 0.
- R4: In eight-channel mode, output frame n on channel c returns input channel c of frame n-D[c]. Frames are counted from 0 at the start of the run. When n < D[c], the result is 0.
- R5: In two-channel mode, only input samples with `in_chan[2:1]` equal to `cfg_src_sel` are stored. Output channel c returns the sample of input channel {`cfg_src_sel`, c[0]} from frame n-D[c], or 0 when n < D[c]. Select codes 0 to 3 pick lanes 0 to 3.
- R6: `out_valid` is 1 exactly in the cycle after a cycle with `out_req` = 1.
- R7: A request for output channel 0 while no complete, unread input frame is held raises `underrun`, clears `running`, and returns 0.
- R8: An input frame that completes while SLACK frames are already pending raises `overrun` and clears `running`. While running, the fill level never exceeds SLACK.
- R9: While running, a change of `cfg_eight_ch`, or a change of `cfg_src_sel` in two-channel mode, clears `running` without raising any flag.
- R10: Lowering `cfg_enable` clears `running`. `overrun`, `underrun` and `cfg_error` keep their values until the next rising edge of `cfg_enable`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Run request; a rising edge starts a run |
| cfg_eight_ch | input | 1 | 1 selects eight-channel mode, 0 selects two-channel mode |
| cfg_src_sel | input | 2 | Stereo input lane stored in two-channel mode |
| cfg_delays | input | 8*DLY_W | Delay of channel i in bits [i*DLY_W +: DLY_W], in sample periods |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 3 | Input channel index |
| in_data | input | DATA_W | Input sample |
| out_req | input | 1 | Output sample request |
| out_chan | input | 3 | Requested output channel |
| out_valid | output | 1 | Requested sample is on `out_data` |
| out_data | output | DATA_W | Delayed sample, or 0 when muted |
| running | output | 1 | Delay operation active |
| cfg_error | output | 1 | Last start was refused because a delay was out of range |
| overrun | output | 1 | Run stopped: input ran ahead of output |
| underrun | output | 1 | Run stopped: output ran ahead of input |

## Verification
The main function is driven in several patterns:
- All delays zero, which shows whether the write and read pointers line up on the same frame.
- Delays at the exact mode limit, accepted and played out past the end of priming, which exposes off-by-one errors at the region boundary.
- Long random runs in both modes, with random delays and a random prefill depth. These separate per-channel region addressing from the shared-pair addressing of two-channel mode, and check the zero output during priming.

One delay value sits between the two mode limits. Asking for it in each mode tells the per-mode range check apart from a single shared limit. Directed starve, flood, configuration-change and enable-drop sequences then check that each stop sets only its own flag.

// File: rtl/av_delay_line.sv
module av_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  parameter int DLY_W  = 16,
  parameter int SLACK  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic                cfg_eight_ch,
  input  logic [1:0]          cfg_src_sel,
  input  logic [8*DLY_W-1:0]  cfg_delays,
  input  logic                in_valid,
  input  logic [2:0]          in_chan,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                out_req,
  input  logic [2:0]          out_chan,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic                running,
  output logic                cfg_error,
  output logic                overrun,
  output logic                underrun
);
  localparam int AW   = $clog2(DEPTH);
  localparam int R8AW = AW - 3;
  localparam int R2AW = AW - 1;
  localparam logic [DLY_W-1:0] MAX8 = DLY_W'(DEPTH / 8 - 1 - SLACK);
  localparam logic [DLY_W-1:0] MAX2 = DLY_W'(DEPTH / 2 - 1 - SLACK);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              en_q, mode_q, rp_wrap;
  logic [1:0]        sel_q;
  logic [AW-1:0]     wp, rp;
  logic [7:0]        too_big;

  for (genvar i = 0; i < 8; i++) begin : g_rng
    assign too_big[i] = cfg_delays[i*DLY_W +: DLY_W] > (cfg_eight_ch ? MAX8 : MAX2);
  end

  wire [AW-1:0]    level   = wp - rp;
  wire             start   = cfg_enable && !en_q;
  wire             in_take = running && in_valid && (mode_q || in_chan[2:1] == sel_q);
  wire             in_last = mode_q ? (in_chan == 3'd7) : (in_chan == {sel_q, 1'b1});
  wire [AW-1:0]    waddr   = mode_q ? {in_chan, wp[R8AW-1:0]} : {in_chan[0], wp[R2AW-1:0]};
  wire [DLY_W-1:0] dsel    = cfg_delays[out_chan*DLY_W +: DLY_W];
  wire [AW-1:0]    back    = rp - AW'(dsel);
  wire [AW-1:0]    raddr   = mode_q ? {out_chan, back[R8AW-1:0]} : {out_chan[0], back[R2AW-1:0]};
  wire             primed  = rp_wrap || (32'(rp) >= 32'(dsel));
  wire             starve  = out_req && out_chan == 3'd0 && level == '0;
  wire             flood   = in_take && in_last && level == AW'(SLACK);
  wire             moved   = cfg_eight_ch != mode_q || (!mode_q && cfg_src_sel != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; running <= 1'b0; cfg_error <= 1'b0; overrun <= 1'b0; underrun <= 1'b0;
      mode_q <= 1'b0; sel_q <= '0; wp <= '0; rp <= '0; rp_wrap <= 1'b0;
    end else begin
      en_q <= cfg_enable;
      if (start) begin
        overrun   <= 1'b0;
        underrun  <= 1'b0;
        cfg_error <= |too_big;
        running   <= ~|too_big;
        mode_q    <= cfg_eight_ch;
        sel_q     <= cfg_src_sel;
        wp <= '0; rp <= '0; rp_wrap <= 1'b0;
      end else if (running) begin
        if (!cfg_enable || moved) running <= 1'b0;
        else if (flood) begin running <= 1'b0; overrun <= 1'b1; end
        else if (starve) begin running <= 1'b0; underrun <= 1'b1; end
        else begin
          if (in_take && in_last) wp <= wp + 1'b1;
          if (out_req && out_chan == 3'd7) begin
            rp <= rp + 1'b1;
            if (&rp) rp_wrap <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) if (in_take) mem[waddr] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= out_req;
      out_data  <= (out_req && running && primed && !starve) ? mem[raddr] : '0;
    end
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |=> out_valid);
  assert_mute_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !running) |=> out_data == '0);
  assert_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !running);
  assert_starve_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !running);
  assert_flood_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !running);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> level <= AW'(SLACK));
  assert_enable_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cfg_enable) |=> !running);
endmodule

// File: tb/av_delay_line_tb.sv
module av_delay_line_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;
  localparam int SLACK = 4;
  localparam int MAX8 = DEPTH / 8 - 1 - SLACK;
  localparam int MAX2 = DEPTH / 2 - 1 - SLACK;

  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_eight_ch = 1;
  logic [1:0] cfg_src_sel = 0;
  logic [127:0] cfg_delays = '0;
  logic in_valid = 0, out_req = 0;
  logic [2:0] in_chan = 0, out_chan = 0;
  logic [15:0] in_data = 0, out_data;
  logic out_valid, running, cfg_error, overrun, underrun;

  av_delay_line #(.DEPTH(DEPTH), .SLACK(SLACK)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_eight_ch(cfg_eight_ch),
    .cfg_src_sel(cfg_src_sel), .cfg_delays(cfg_delays), .in_valid(in_valid),
    .in_chan(in_chan), .in_data(in_data), .out_req(out_req), .out_chan(out_chan),
    .out_valid(out_valid), .out_data(out_data), .running(running),
    .cfg_error(cfg_error), .overrun(overrun), .underrun(underrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int dly [8];
  logic [15:0] hist [1024][8];
  int in_f = 0, out_f = 0;
  bit m8 = 1;
  int sel = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_smp(int f, int c);
    if (f < dly[c]) return 16'h0;
    if (m8) return hist[(f - dly[c]) % 1024][c];
    return hist[(f - dly[c]) % 1024][sel * 2 + c % 2];
  endfunction

  task automatic configure(bit eight, int s);
    m8 = eight; sel = s;
    @(negedge clk);
    cfg_enable = 0; cfg_eight_ch = eight; cfg_src_sel = 2'(s);
    for (int i = 0; i < 8; i++) cfg_delays[i*16 +: 16] = 16'(dly[i]);
    @(negedge clk);
    cfg_enable = 1;
    @(negedge clk);
    in_f = 0; out_f = 0;
  endtask

  task automatic send_frame();
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      in_valid = 1; in_chan = 3'(c); in_data = 16'($urandom);
      hist[in_f % 1024][c] = in_data;
    end
    @(negedge clk);
    in_valid = 0;
    in_f++;
  endtask

  task automatic read_frame(string tag, bit muted);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      out_req = 1; out_chan = 3'(c);
      @(negedge clk);
      out_req = 0;
      check({tag, " R6 valid"}, 32'(out_valid), 32'd1);
      check(tag, 32'(out_data), muted ? 32'd0 : 32'(expect_smp(out_f, c)));
    end
    out_f++;
  endtask

  task automatic stream(string tag, int pre, int frames);
    for (int i = 0; i < pre; i++) send_frame();
    for (int i = 0; i < frames; i++) begin
      send_frame();
      read_frame(tag, 0);
    end
    check({tag, " R8 still running"}, 32'(running), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 running", 32'(running), 0);
    check("R1 flags", {29'd0, cfg_error, overrun, underrun}, 0);
    check("R1 out", {15'd0, out_valid, out_data}, 0);

    // R3: muted while idle
    read_frame("R3 idle mute", 1);

    // R4: zero delay in eight-channel mode
    for (int i = 0; i < 8; i++) dly[i] = 0;
    configure(1, 0);
    check("R2 start", 32'(running), 1);
    stream("R4 zero delay", 0, 10);

    // R2/R4: limit delays accepted and played past priming
    for (int i = 0; i < 8; i++) dly[i] = (i % 2) ? MAX8 : MAX8 - i;
    configure(1, 0);
    check("R2 limit accepted", {30'd0, running, cfg_error}, 32'd2);
    stream("R4 limit delay", 1, MAX8 + 8);

    // R2: one above eight-channel limit refused, same value accepted in two-channel mode
    dly[5] = MAX8 + 1;
    configure(1, 0);
    check("R2 8ch refuse", {30'd0, running, cfg_error}, 32'd1);
    read_frame("R3 refused mute", 1);
    configure(0, 2);
    check("R2 2ch accept", {30'd0, running, cfg_error}, 32'd2);
    dly[2] = MAX2 + 1;
    configure(0, 2);
    check("R2 2ch refuse", {30'd0, running, cfg_error}, 32'd1);

    // R4: random eight-channel run
    for (int i = 0; i < 8; i++) dly[i] = int'($urandom_range(MAX8, 0));
    configure(1, 0);
    stream("R4 random 8ch", int'($urandom_range(SLACK - 1, 0)), 200);

    // R5: random two-channel runs on every select code
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 8; i++) dly[i] = int'($urandom_range(s == 3 ? 40 : 160, 0));
      configure(0, s);
      stream("R5 random 2ch", int'($urandom_range(SLACK - 1, 0)), s == 3 ? 60 : 170);
    end

    // R7: request before any input frame
    for (int i = 0; i < 8; i++) dly[i] = 0;
    configure(1, 0);
    read_frame("R7 starve data", 1);
    check("R7 underrun", {30'd0, running, underrun}, 32'd1);
    check("R7 no overrun", 32'(overrun), 0);

    // R10: flag holds after enable drop, cleared by next start
    @(negedge clk); cfg_enable = 0;
    @(negedge clk);
    check("R10 flag held", 32'(underrun), 1);
    configure(1, 0);
    check("R10 flag cleared", {30'd0, running, underrun}, 32'd2);

    // R8: SLACK+1 unread frames
    for (int i = 0; i <= SLACK; i++) send_frame();
    check("R8 overrun", {30'd0, running, overrun}, 32'd1);
    check("R8 no underrun", 32'(underrun), 0);

    // R9: mode change while running
    configure(1, 0);
    send_frame();
    @(negedge clk); cfg_eight_ch = 0;
    @(negedge clk);
    check("R9 mode stop", {29'd0, running, overrun, underrun}, 0);
    read_frame("R3 after stop", 1);

    // R9: select change in two-channel mode
    configure(0, 1);
    @(negedge clk); cfg_src_sel = 2'd3;
    @(negedge clk);
    check("R9 select stop", {29'd0, running, overrun, underrun}, 0);

    // R10: enable drop stops a healthy run
    configure(1, 0);
    send_frame();
    @(negedge clk); cfg_enable = 0;
    @(negedge clk);
    check("R10 enable drop", 32'(running), 0);
    read_frame("R3 enable low mute", 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule